// File: doc/BRIEF.md
# Bus Snoop Intervention Controller

This block sits beside a local data cache and watches bus cycles that a different bus master starts. On the first clock edge that shows the start strobe, it captures the cycle's attributes. It then decides whether the cycle is a snoop candidate from its transfer type and its 2-bit snoop code. A candidate is checked through a request/response port to an external tag model, which answers hit and dirty. During that check, a memory-inhibit line holds memory off. The block then does one of three things: it releases memory to finish the cycle, it asks the tag model to invalidate the line, or it stays in charge and answers the other master as a slave.

When a cycle is not snooped, or after inhibit is released, the block follows the cycle to its end by classifying and counting terminations. The cache arrays, the data path and the generation of snoop codes are outside this block.

States: `S_RESET` (inhibit asserted) goes to `S_IDLE` on the first clock. `S_IDLE` goes to `S_EVAL` on a start strobe. `S_EVAL` goes to `S_LOOKUP` when the cycle is snoopable, and to `S_FOLLOW` when it is not. `S_LOOKUP` waits for the tag answer and then goes to `S_SLAVE` (dirty hit that needs sink or source), to `S_INVAL` (write hit under the invalidate code) or to `S_FOLLOW` (any other answer). `S_INVAL` goes to `S_FOLLOW` on acknowledge. `S_SLAVE` goes to `S_IDLE` after its last beat. `S_FOLLOW` goes to `S_IDLE` on the final termination.

Top module: `snp_ctl`

## Requirements
- R1: Memory-inhibit is high while reset is applied and for the first clock after reset is released. It is low once the controller is idle.
- R2: Byte offset, size, transfer modifier and read/write (1 = read) are captured on the edge where the start strobe is seen. They are presented unchanged on the lookup port even if the inputs change afterwards.
- R3: A cycle is snooped only when its transfer type is 00 or 01 and its snoop code is 01 or 10. For any other cycle there is no lookup request and inhibit is low from the second edge on. Inhibit is high in the cycle after the strobe for every cycle. Snoop codes: 00 disabled, 01 sink write / source read, 10 invalidate write / source read, 11 reserved and treated as disabled. Size codes: 00 long word, 01 byte, 10 word, 11 line, and every one of them can be snooped.
- R4: Inhibit stays high while a lookup is pending. Transfer-acknowledges seen during that time are not counted.
- R5: A miss, a clean hit, or a write miss under code 10 releases inhibit, and memory then completes the cycle.
- R6: A dirty hit on a read under code 01 or 10, or on a write under code 01, keeps inhibit high. The block then drives one slave acknowledge per beat (four for a line, one for other sizes), drops inhibit and goes idle.
- R7: A write hit under code 10 raises an invalidate request on the lookup port and then releases inhibit.
- R8: Terminations are classified as follows. Acknowledge with error-acknowledge is a retry. Error-acknowledge alone is a bus error. Acknowledge with burst-inhibit on a line cycle is burst-inhibited. Acknowledge alone is normal. Retry and bus error end the cycle at once.
- R9: While following, a line cycle ends after four normal acknowledges and any other size ends after one. A start strobe that arrives before the cycle ends is ignored.
- R10: A burst-inhibited line cycle ends after that termination. Each long-word cycle that follows gets its own full lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| abm_ts_i | input | 1 | Transfer-start strobe from the other master |
| abm_ofs_i | input | 2 | Address byte offset |
| abm_size_i | input | 2 | Transfer size code |
| abm_tt_i | input | 2 | Transfer type |
| abm_tm_i | input | 3 | Transfer modifier |
| abm_rw_i | input | 1 | 1 = read, 0 = write |
| abm_sc_i | input | 2 | Snoop-control code |
| bus_ta_i | input | 1 | Transfer acknowledge seen on the bus |
| bus_tea_i | input | 1 | Transfer error acknowledge seen on the bus |
| bus_tbi_i | input | 1 | Burst-inhibit seen on the bus |
| mem_inh_o | output | 1 | Memory inhibit, active high |
| slv_ta_o | output | 1 | Acknowledge driven while acting as slave |
| lk_req_o | output | 1 | Tag lookup request |
| lk_inval_o | output | 1 | Invalidate qualifier on the request |
| lk_ofs_o | output | 2 | Captured byte offset |
| lk_size_o | output | 2 | Captured size |
| lk_tm_o | output | 3 | Captured transfer modifier |
| lk_rw_o | output | 1 | Captured read/write |
| lk_ack_i | input | 1 | Tag model answer valid |
| lk_hit_i | input | 1 | Tag hit |
| lk_dirty_i | input | 1 | Hit line is dirty |

## Verification
Each output is due at a fixed distance from the strobe edge:
- Inhibit is high one edge after the strobe.
- On the second edge, the lookup request appears, or inhibit falls for an unsnooped cycle.
- With a tag model that answers at once, the third edge brings the slave beats, the invalidate request, or the released inhibit.
- Each termination is counted on the edge that samples it.

The bench drives every input one time unit after a rising edge and reads the outputs at that same point, so every check sees the state left by one known edge. Whether a cycle has ended is observed at the ports: a probing strobe is sent, and the bench checks whether inhibit rises one edge later.

// File: rtl/snp_pkg.sv
`timescale 1ns/1ps
package snp_pkg;

    typedef enum logic [2:0] {
        S_RESET,
        S_IDLE,
        S_EVAL,
        S_LOOKUP,
        S_INVAL,
        S_SLAVE,
        S_FOLLOW
    } snp_state_t;

    typedef enum logic [2:0] {
        TRM_NONE,
        TRM_NORMAL,
        TRM_ERROR,
        TRM_RETRY,
        TRM_BINH
    } snp_term_t;

    typedef struct packed {
        logic [1:0] ofs;
        logic [1:0] size;
        logic [2:0] tm;
        logic       rw;
        logic [1:0] tt;
        logic [1:0] sc;
    } snp_attr_t;

    localparam logic [1:0] SZ_LINE  = 2'b11;
    localparam logic [1:0] SC_OFF   = 2'b00;
    localparam logic [1:0] SC_SINK  = 2'b01;
    localparam logic [1:0] SC_INVAL = 2'b10;

endpackage

// File: rtl/snp_term_class.sv
`timescale 1ns/1ps
module snp_term_class
    import snp_pkg::*;
(
    input  logic      ta_i,
    input  logic      tea_i,
    input  logic      tbi_i,
    input  logic      is_line_i,
    output snp_term_t term_o
);

    always_comb begin
        if (ta_i && tea_i) begin
            term_o = TRM_RETRY;
        end else if (tea_i) begin
            term_o = TRM_ERROR;
        end else if (ta_i && tbi_i && is_line_i) begin
            term_o = TRM_BINH;
        end else if (ta_i) begin
            term_o = TRM_NORMAL;
        end else begin
            term_o = TRM_NONE;
        end
    end

endmodule

// File: rtl/snp_policy.sv
`timescale 1ns/1ps
module snp_policy
    import snp_pkg::*;
#(
    parameter int LINE_BEATS = 4,
    parameter int CW         = 3
) (
    input  logic [1:0]    size_i,
    input  logic          rw_i,
    input  logic [1:0]    tt_i,
    input  logic [1:0]    sc_i,
    input  logic          hit_i,
    input  logic          dirty_i,
    output logic          snoop_en_o,
    output logic          is_line_o,
    output logic [CW-1:0] beats_o,
    output logic          want_slave_o,
    output logic          want_inval_o
);

    logic tt_ok, sc_ok, dirty_hit;

    assign tt_ok      = (tt_i[1] == 1'b0);
    assign sc_ok      = (sc_i == SC_SINK) || (sc_i == SC_INVAL);
    assign snoop_en_o = tt_ok && sc_ok;
    assign is_line_o  = (size_i == SZ_LINE);
    assign beats_o    = is_line_o ? CW'(LINE_BEATS) : CW'(1);
    assign dirty_hit  = hit_i && dirty_i;

    always_comb begin
        want_slave_o = 1'b0;
        want_inval_o = 1'b0;
        if (snoop_en_o) begin
            if (rw_i) begin
                want_slave_o = dirty_hit;
            end else if (sc_i == SC_SINK) begin
                want_slave_o = dirty_hit;
            end else begin
                want_inval_o = hit_i;
            end
        end
    end

endmodule

// File: rtl/snp_beat_cnt.sv
`timescale 1ns/1ps
module snp_beat_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [CW-1:0] target_i,
    output logic          at_last_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign at_last_o = (cnt == (target_i - CW'(1)));

endmodule

// File: rtl/snp_ctl.sv
`timescale 1ns/1ps
module snp_ctl
    import snp_pkg::*;
#(
    parameter int LINE_BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abm_ts_i,
    input  logic [1:0] abm_ofs_i,
    input  logic [1:0] abm_size_i,
    input  logic [1:0] abm_tt_i,
    input  logic [2:0] abm_tm_i,
    input  logic       abm_rw_i,
    input  logic [1:0] abm_sc_i,
    input  logic       bus_ta_i,
    input  logic       bus_tea_i,
    input  logic       bus_tbi_i,
    output logic       mem_inh_o,
    output logic       slv_ta_o,
    output logic       lk_req_o,
    output logic       lk_inval_o,
    output logic [1:0] lk_ofs_o,
    output logic [1:0] lk_size_o,
    output logic [2:0] lk_tm_o,
    output logic       lk_rw_o,
    input  logic       lk_ack_i,
    input  logic       lk_hit_i,
    input  logic       lk_dirty_i
);

    localparam int CW = $clog2(LINE_BEATS + 1);

    snp_state_t    st, nx;
    snp_attr_t     attr;
    snp_term_t     term;
    logic [1:0]    tt_eff, sc_eff;
    logic          snoop_en, is_line, want_slave, want_inval;
    logic [CW-1:0] beats;
    logic          cnt_clr, cnt_inc, at_last;

    // Cycle attributes: the strobe edge fixes offset, size, modifier and direction.
    // Type and snoop code are judged live in S_EVAL and kept from that edge on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr <= '0;
        end else begin
            if (st == S_IDLE && abm_ts_i) begin
                attr.ofs  <= abm_ofs_i;
                attr.size <= abm_size_i;
                attr.tm   <= abm_tm_i;
                attr.rw   <= abm_rw_i;
            end
            if (st == S_EVAL) begin
                attr.tt <= abm_tt_i;
                attr.sc <= abm_sc_i;
            end
        end
    end

    assign tt_eff = (st == S_EVAL) ? abm_tt_i : attr.tt;
    assign sc_eff = (st == S_EVAL) ? abm_sc_i : attr.sc;

    snp_policy #(
        .LINE_BEATS (LINE_BEATS),
        .CW         (CW)
    ) u_policy (
        .size_i       (attr.size),
        .rw_i         (attr.rw),
        .tt_i         (tt_eff),
        .sc_i         (sc_eff),
        .hit_i        (lk_hit_i),
        .dirty_i      (lk_dirty_i),
        .snoop_en_o   (snoop_en),
        .is_line_o    (is_line),
        .beats_o      (beats),
        .want_slave_o (want_slave),
        .want_inval_o (want_inval)
    );

    snp_term_class u_term (
        .ta_i      (bus_ta_i),
        .tea_i     (bus_tea_i),
        .tbi_i     (bus_tbi_i),
        .is_line_i (is_line),
        .term_o    (term)
    );

    assign cnt_clr = (st == S_IDLE);
    assign cnt_inc = (st == S_SLAVE) || (st == S_FOLLOW && term == TRM_NORMAL);

    snp_beat_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cnt_clr),
        .inc_i     (cnt_inc),
        .target_i  (beats),
        .at_last_o (at_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_RESET;
        end else begin
            st <= nx;
        end
    end

    // Transitions
    always_comb begin
        nx = st;
        unique case (st)
            S_RESET: nx = S_IDLE;
            S_IDLE: begin
                if (abm_ts_i) nx = S_EVAL;
            end
            S_EVAL: nx = snoop_en ? S_LOOKUP : S_FOLLOW;
            S_LOOKUP: begin
                if (lk_ack_i) begin
                    if (want_slave)      nx = S_SLAVE;
                    else if (want_inval) nx = S_INVAL;
                    else                 nx = S_FOLLOW;
                end
            end
            S_INVAL: begin
                if (lk_ack_i) nx = S_FOLLOW;
            end
            S_SLAVE: begin
                if (at_last) nx = S_IDLE;
            end
            S_FOLLOW: begin
                unique case (term)
                    TRM_RETRY, TRM_ERROR, TRM_BINH: nx = S_IDLE;
                    TRM_NORMAL: begin
                        if (at_last) nx = S_IDLE;
                    end
                    default: nx = S_FOLLOW;
                endcase
            end
            default: nx = S_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        mem_inh_o  = 1'b0;
        slv_ta_o   = 1'b0;
        lk_req_o   = 1'b0;
        lk_inval_o = 1'b0;
        unique case (st)
            S_RESET:  mem_inh_o = 1'b1;
            S_EVAL:   mem_inh_o = 1'b1;
            S_LOOKUP: begin
                mem_inh_o = 1'b1;
                lk_req_o  = 1'b1;
            end
            S_INVAL: begin
                mem_inh_o  = 1'b1;
                lk_req_o   = 1'b1;
                lk_inval_o = 1'b1;
            end
            S_SLAVE: begin
                mem_inh_o = 1'b1;
                slv_ta_o  = 1'b1;
            end
            default: mem_inh_o = 1'b0;
        endcase
    end

    assign lk_ofs_o  = attr.ofs;
    assign lk_size_o = attr.size;
    assign lk_tm_o   = attr.tm;
    assign lk_rw_o   = attr.rw;

endmodule

// File: rtl/snp_ctl_chk.sv
`timescale 1ns/1ps
module snp_ctl_chk
    import snp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input snp_state_t st,
    input logic       mem_inh,
    input logic       slv_ta,
    input logic       lk_req,
    input logic       lk_inval,
    input logic       bus_ta,
    input logic       bus_tea
);

    p_reset_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RESET) |=> (st == S_IDLE));

    p_lookup_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> mem_inh);

    p_follow_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FOLLOW) |-> !mem_inh);

    p_slave_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SLAVE) |-> (slv_ta && mem_inh));

    p_inval_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_inval |-> lk_req);

    p_retry_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FOLLOW && bus_ta && bus_tea) |=> (st == S_IDLE));

endmodule

bind snp_ctl snp_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .mem_inh  (mem_inh_o),
    .slv_ta   (slv_ta_o),
    .lk_req   (lk_req_o),
    .lk_inval (lk_inval_o),
    .bus_ta   (bus_ta_i),
    .bus_tea  (bus_tea_i)
);

// File: tb/snp_ctl_tb.sv
`timescale 1ns/1ps
module snp_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       abm_ts_i = 1'b0;
    logic [1:0] abm_ofs_i = '0, abm_size_i = '0, abm_tt_i = '0, abm_sc_i = '0;
    logic [2:0] abm_tm_i = '0;
    logic       abm_rw_i = 1'b0;
    logic       bus_ta_i = 1'b0, bus_tea_i = 1'b0, bus_tbi_i = 1'b0;
    logic       mem_inh_o, slv_ta_o, lk_req_o, lk_inval_o, lk_rw_o;
    logic [1:0] lk_ofs_o, lk_size_o;
    logic [2:0] lk_tm_o;
    logic       lk_ack_i = 1'b1, lk_hit_i = 1'b0, lk_dirty_i = 1'b0;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    snp_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .abm_ts_i(abm_ts_i), .abm_ofs_i(abm_ofs_i),
        .abm_size_i(abm_size_i), .abm_tt_i(abm_tt_i), .abm_tm_i(abm_tm_i),
        .abm_rw_i(abm_rw_i), .abm_sc_i(abm_sc_i), .bus_ta_i(bus_ta_i),
        .bus_tea_i(bus_tea_i), .bus_tbi_i(bus_tbi_i), .mem_inh_o(mem_inh_o),
        .slv_ta_o(slv_ta_o), .lk_req_o(lk_req_o), .lk_inval_o(lk_inval_o),
        .lk_ofs_o(lk_ofs_o), .lk_size_o(lk_size_o), .lk_tm_o(lk_tm_o),
        .lk_rw_o(lk_rw_o), .lk_ack_i(lk_ack_i), .lk_hit_i(lk_hit_i),
        .lk_dirty_i(lk_dirty_i)
    );

    // Vector fields: tt[10:9] sc[8:7] rw[6] size[5:4] hit[3] dirty[2] path[1:0]
    // path: 0 not snooped, 1 released after lookup, 2 slave response, 3 invalidate
    localparam int NV = 13;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {2'd0, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 2'd0},
        {2'd0, 2'b11, 1'b0, 2'b11, 1'b1, 1'b1, 2'd0},
        {2'd2, 2'b01, 1'b1, 2'b11, 1'b1, 1'b1, 2'd0},
        {2'd1, 2'b01, 1'b1, 2'b01, 1'b0, 1'b0, 2'd1},
        {2'd0, 2'b01, 1'b1, 2'b11, 1'b1, 1'b0, 2'd1},
        {2'd0, 2'b01, 1'b1, 2'b11, 1'b1, 1'b1, 2'd2},
        {2'd0, 2'b01, 1'b0, 2'b10, 1'b1, 1'b1, 2'd2},
        {2'd0, 2'b10, 1'b1, 2'b00, 1'b1, 1'b1, 2'd2},
        {2'd0, 2'b10, 1'b0, 2'b11, 1'b1, 1'b1, 2'd3},
        {2'd1, 2'b10, 1'b0, 2'b01, 1'b1, 1'b0, 2'd3},
        {2'd0, 2'b10, 1'b0, 2'b10, 1'b0, 1'b0, 2'd1},
        {2'd3, 2'b10, 1'b1, 2'b11, 1'b1, 1'b1, 2'd0},
        {2'd0, 2'b01, 1'b0, 2'b11, 1'b1, 1'b0, 2'd1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] tt, input logic [1:0] sc, input logic rw,
                         input logic [1:0] size);
        abm_ts_i = 1'b1; abm_tt_i = tt; abm_sc_i = sc; abm_rw_i = rw;
        abm_size_i = size; abm_ofs_i = 2'd1; abm_tm_i = 3'd2;
        step();
        abm_ts_i = 1'b0;
    endtask

    task automatic terms(input int n);
        for (int i = 0; i < n; i++) begin
            bus_ta_i = 1'b1;
            step();
        end
        bus_ta_i = 1'b0;
    endtask

    // Sends a strobe; reports whether the controller was idle (inhibit rises).
    task automatic probe(input bit exp_idle, input string req);
        start(2'd0, 2'b00, 1'b1, 2'b00);
        chk(mem_inh_o == exp_idle, req, "probe strobe accepted", mem_inh_o, exp_idle);
        if (mem_inh_o) begin
            step();
            terms(1);
        end
    endtask

    task automatic run_cycle(input logic [10:0] v);
        logic [1:0] tt, sc, size, path;
        logic rw;
        bit   line, look;
        int   pulses, guard;
        tt = v[10:9]; sc = v[8:7]; rw = v[6]; size = v[5:4];
        lk_hit_i = v[3]; lk_dirty_i = v[2]; path = v[1:0];
        line = (size == 2'b11);
        look = (path != 2'd0);
        start(tt, sc, rw, size);
        chk(mem_inh_o == 1'b1, "R3", "inhibit after strobe", mem_inh_o, 1);
        step();
        chk(lk_req_o == look, "R3", "lookup request", lk_req_o, look);
        chk(mem_inh_o == look, "R4", "inhibit during decision", mem_inh_o, look);
        if (look) begin
            chk(lk_size_o == size && lk_rw_o == rw, "R2", "captured size/rw",
                {lk_size_o, lk_rw_o}, {size, rw});
            step();
        end
        if (path == 2'd2) begin
            pulses = 0; guard = 0;
            while (mem_inh_o && guard < 10) begin
                if (slv_ta_o) pulses++;
                guard++;
                step();
            end
            chk(pulses == (line ? 4 : 1), "R6", "slave beats", pulses, line ? 4 : 1);
            chk(mem_inh_o == 1'b0, "R6", "inhibit after slave", mem_inh_o, 0);
        end else begin
            if (path == 2'd3) begin
                chk(lk_req_o && lk_inval_o, "R7", "invalidate request",
                    {lk_req_o, lk_inval_o}, 3);
                step();
                chk(mem_inh_o == 1'b0, "R7", "release after invalidate", mem_inh_o, 0);
            end else if (path == 2'd1) begin
                chk(mem_inh_o == 1'b0, "R5", "release after lookup", mem_inh_o, 0);
            end
            terms(line ? 4 : 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(mem_inh_o == 1'b1, "R1", "inhibit in reset", mem_inh_o, 1);
        rst_n = 1'b1;
        #1;
        chk(mem_inh_o == 1'b1, "R1", "inhibit before first clock", mem_inh_o, 1);
        step();
        chk(mem_inh_o == 1'b0, "R1", "inhibit when idle", mem_inh_o, 0);

        for (int k = 0; k < NV; k++) run_cycle(VEC[k]);

        // R2, R4, R9: acknowledges ignored during a stalled lookup
        lk_ack_i = 1'b0; lk_hit_i = 1'b0; lk_dirty_i = 1'b0;
        abm_ts_i = 1'b1; abm_tt_i = 2'd0; abm_sc_i = 2'b01; abm_rw_i = 1'b1;
        abm_size_i = 2'b11; abm_ofs_i = 2'd2; abm_tm_i = 3'd5;
        step();
        abm_ts_i = 1'b0; abm_ofs_i = 2'd0; abm_size_i = 2'b00; abm_tm_i = 3'd0; abm_rw_i = 1'b0;
        step();
        chk(lk_ofs_o == 2'd2 && lk_tm_o == 3'd5, "R2", "captured offset/modifier",
            {lk_ofs_o, lk_tm_o}, {2'd2, 3'd5});
        chk(lk_size_o == 2'b11 && lk_rw_o == 1'b1, "R2", "captured size/rw held",
            {lk_size_o, lk_rw_o}, 7);
        bus_ta_i = 1'b1;
        step();
        chk(mem_inh_o == 1'b1, "R4", "inhibit while lookup stalls", mem_inh_o, 1);
        step();
        chk(mem_inh_o == 1'b1, "R4", "inhibit still held", mem_inh_o, 1);
        bus_ta_i = 1'b0; lk_ack_i = 1'b1;
        step();
        chk(mem_inh_o == 1'b0, "R5", "release on miss", mem_inh_o, 0);
        terms(3);
        probe(1'b0, "R9");
        terms(1);
        probe(1'b1, "R9");

        // R8: bus error and retry end an unsnooped line cycle at once
        start(2'd0, 2'b00, 1'b1, 2'b11);
        step();
        bus_tea_i = 1'b1; step(); bus_tea_i = 1'b0;
        probe(1'b1, "R8");
        start(2'd0, 2'b00, 1'b0, 2'b11);
        step();
        bus_ta_i = 1'b1; bus_tea_i = 1'b1; step();
        bus_ta_i = 1'b0; bus_tea_i = 1'b0;
        probe(1'b1, "R8");

        // R10: burst-inhibited snooped line, then four long-word snoops
        lk_hit_i = 1'b0; lk_dirty_i = 1'b0;
        start(2'd0, 2'b01, 1'b1, 2'b11);
        step(); step();
        bus_ta_i = 1'b1; bus_tbi_i = 1'b1; step();
        bus_ta_i = 1'b0; bus_tbi_i = 1'b0;
        probe(1'b1, "R10");
        for (int j = 0; j < 4; j++) run_cycle({2'd0, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 2'd1});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule